// File: doc/BRIEF.md
# PASID Capability and Prefix Gate

This block holds the device-side registers of the PASID extended capability in configuration space, and it decides, request by request, whether an outgoing transaction may carry a PASID prefix. Configuration software reads the header and the capability word, then sets the enable bits in the control half-word through a dword-addressed write port with byte enables. The capability word advertises the supported features and the maximum PASID width. The control word's enable bits are then applied to every request the device sends.

On the transmit side the requester presents a request kind, a flag that asks for a prefix, the 20-bit PASID, and the execute and privileged wishes. One clock later the block returns the prefix fields it allows. The execute and privileged bits are dropped unless the matching feature is both supported and enabled. Completions never get a prefix. A PASID value too wide for the advertised width is refused and flagged as an error.

Top module: `pasid_cap_gate`

## Requirements
- R1: Dword offset 0 reads {NEXT_PTR[11:0], CAP_VER[3:0], 16'h001B} (capability ID in bits 15:0, version in 19:16, next pointer in 31:20) and ignores writes.
- R2: Dword offset 1 bits 15:0 read as the read-only capability word: bit 1 = EXEC_SUP, bit 2 = PRIV_SUP, bits 12:8 = MAX_LOG2, and bits 0, 7:3 and 15:13 read 0.
- R3: Dword offset 1 bits 31:16 form the control word, with bit 16 = PASID enable, bit 17 = execute enable and bit 18 = privileged enable. A write to offset 1 with byte enable 2 set loads them from write-data bits 18:16. Without byte enable 2 the write leaves them unchanged. Bits 31:19 read 0.
- R4: The execute enable (bit 17) and the privileged enable (bit 18) can be set only when the matching capability bit is 1. Otherwise they read 0 whatever is written.
- R5: While PASID enable is 0, no request gets a prefix (pfx_present = 0).
- R6: A request of kind 2'b10 (completion) never gets a prefix. Kinds 2'b00 (read), 2'b01 (write) and 2'b11 (message) may get one.
- R7: pfx_exec is 1 only when a prefix is emitted, execute was requested, and execute enable is 1.
- R8: pfx_priv is 1 only when a prefix is emitted, privileged mode was requested, and privileged enable is 1.
- R9: When a request would otherwise get a prefix but its PASID has any bit at position MAX_LOG2 or above set, no prefix is emitted and pfx_range_err is 1 for that request.
- R10: Every transmit output is registered with a latency of one clock. pfx_valid repeats tx_valid, and pfx_pasid carries the PASID when a prefix is emitted and 0 otherwise.
- R11: Dword offsets other than 0 and 1 read 0, and writes to them change nothing.
- R12: While reset is held, and until the synchronised reset is released, all transmit outputs are 0 and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_dw_off | input | OFF_W | Dword offset within the capability |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_off (combinational) |
| tx_valid | input | 1 | A request is presented this cycle |
| tx_kind | input | 2 | Request kind: 00 read, 01 write, 10 completion, 11 message |
| tx_pasid_want | input | 1 | Requester asks for a PASID prefix |
| tx_pasid | input | 20 | Requested PASID |
| tx_exec_req | input | 1 | Requested execute bit |
| tx_priv_req | input | 1 | Requested privileged bit |
| pfx_valid | output | 1 | Registered copy of tx_valid |
| pfx_present | output | 1 | Prefix is attached to the request |
| pfx_pasid | output | 20 | PASID field of the prefix, 0 when absent |
| pfx_exec | output | 1 | Execute bit of the prefix |
| pfx_priv | output | 1 | Privileged bit of the prefix |
| pfx_range_err | output | 1 | PASID exceeded the advertised width |

## Verification
The bench builds two copies side by side. The first has MAX_LOG2 = 12, execute supported, privileged not supported and a non-zero next pointer. The second has MAX_LOG2 = 20, execute not supported and privileged supported. With the narrow width of the first copy, the range error and its suppression of the prefix can be reached with ordinary random PASIDs. The second copy shows that no error arises at full width. The opposite support bits let one stream of control writes show both the write-masking of unsupported enables and the gating of each prefix bit.

// File: rtl/pasid_cap_pkg.sv
package pasid_cap_pkg;
  localparam int unsigned PASID_W = 20;
  localparam logic [15:0] EXT_CAP_ID = 16'h001B;

  typedef enum logic [1:0] {
    REQ_READ  = 2'b00,
    REQ_WRITE = 2'b01,
    REQ_CPL   = 2'b10,
    REQ_MSG   = 2'b11
  } req_kind_e;

  typedef struct packed {
    logic en;
    logic exe;
    logic prv;
  } ctrl_t;

  typedef struct packed {
    logic               vld;
    logic               pfx;
    logic               exe;
    logic               prv;
    logic               err;
    logic [PASID_W-1:0] pasid;
  } pfx_out_t;
endpackage

// File: rtl/pasid_rst_sync.sv
module pasid_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pasid_cfg_regs.sv
module pasid_cfg_regs
  import pasid_cap_pkg::*;
#(
  parameter int unsigned OFF_W    = 3,
  parameter logic [3:0]  CAP_VER  = 4'h1,
  parameter logic [11:0] NEXT_PTR = 12'h000,
  parameter bit          EXEC_SUP = 1'b1,
  parameter bit          PRIV_SUP = 1'b1,
  parameter int unsigned MAX_LOG2 = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] dw_off,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output ctrl_t            ctrl
);
  localparam logic [OFF_W-1:0] HDR_DW    = OFF_W'(0);
  localparam logic [OFF_W-1:0] CAPCTL_DW = OFF_W'(1);
  localparam logic [15:0] CAP_WORD =
    {3'b000, 5'(MAX_LOG2), 5'b00000, PRIV_SUP, EXEC_SUP, 1'b0};

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  ctrl_wr;
  logic  unused_wbits;

  assign unused_wbits = ^{wdata[31:19], wdata[15:0], be[3], be[1:0]};

  always_comb begin
    ctrl_wr   = wr_en && (dw_off == CAPCTL_DW) && be[2];
    ctrl_d.en  = wdata[16];
    ctrl_d.exe = EXEC_SUP & wdata[17];
    ctrl_d.prv = PRIV_SUP & wdata[18];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  always_comb begin
    case (dw_off)
      HDR_DW:    rdata = {NEXT_PTR, CAP_VER, EXT_CAP_ID};
      CAPCTL_DW: rdata = {13'b0, ctrl_q.prv, ctrl_q.exe, ctrl_q.en, CAP_WORD};
      default:   rdata = 32'h0;
    endcase
  end

  assign ctrl = ctrl_q;

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && dw_off == CAPCTL_DW && be[2]) |=> $stable(ctrl_q));

  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dw_off == CAPCTL_DW && be[2]) |=> (ctrl_q.en == $past(wdata[16])));

  // R4
  ctrl_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.exe |-> EXEC_SUP) and (ctrl_q.prv |-> PRIV_SUP));
endmodule

// File: rtl/pasid_pfx_gate.sv
module pasid_pfx_gate
  import pasid_cap_pkg::*;
#(
  parameter int unsigned MAX_LOG2 = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_t              ctrl,
  input  logic               tx_valid,
  input  logic [1:0]         tx_kind,
  input  logic               tx_want,
  input  logic [PASID_W-1:0] tx_pasid,
  input  logic               tx_exec,
  input  logic               tx_priv,
  output pfx_out_t           pout
);
  localparam logic [PASID_W-1:0] HI_MASK = (MAX_LOG2 >= PASID_W) ? '0 :
    PASID_W'({PASID_W{1'b1}} << MAX_LOG2);

  pfx_out_t out_d;
  pfx_out_t out_q;
  logic     eligible;
  logic     too_wide;

  always_comb begin
    eligible   = tx_valid && tx_want && ctrl.en && (tx_kind != REQ_CPL);
    too_wide   = |(tx_pasid & HI_MASK);
    out_d.vld  = tx_valid;
    out_d.err  = eligible && too_wide;
    out_d.pfx  = eligible && !too_wide;
    out_d.exe  = out_d.pfx && tx_exec && ctrl.exe;
    out_d.prv  = out_d.pfx && tx_priv && ctrl.prv;
    out_d.pasid = out_d.pfx ? tx_pasid : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign pout = out_q;

  // R5
  no_pfx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.pfx |-> $past(ctrl.en));

  // R6
  no_pfx_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.pfx |-> ($past(tx_kind) != REQ_CPL));

  // R7
  exec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.exe |-> (out_q.pfx && $past(ctrl.exe) && $past(tx_exec)));

  // R8
  priv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.prv |-> (out_q.pfx && $past(ctrl.prv) && $past(tx_priv)));

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.err |-> (!out_q.pfx && $past(tx_pasid) != out_q.pasid));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_valid) |-> out_q.vld);
endmodule

// File: rtl/pasid_cap_gate.sv
module pasid_cap_gate
  import pasid_cap_pkg::*;
#(
  parameter int unsigned OFF_W      = 3,
  parameter logic [3:0]  CAP_VER    = 4'h1,
  parameter logic [11:0] NEXT_PTR   = 12'h000,
  parameter bit          EXEC_SUP   = 1'b1,
  parameter bit          PRIV_SUP   = 1'b1,
  parameter int unsigned MAX_LOG2   = 20,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [OFF_W-1:0] cfg_dw_off,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             tx_valid,
  input  logic [1:0]       tx_kind,
  input  logic             tx_pasid_want,
  input  logic [19:0]      tx_pasid,
  input  logic             tx_exec_req,
  input  logic             tx_priv_req,
  output logic             pfx_valid,
  output logic             pfx_present,
  output logic [19:0]      pfx_pasid,
  output logic             pfx_exec,
  output logic             pfx_priv,
  output logic             pfx_range_err
);
  logic     rst_n_int;
  ctrl_t    ctrl;
  pfx_out_t pout;

  pasid_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  pasid_cfg_regs #(
    .OFF_W    (OFF_W),
    .CAP_VER  (CAP_VER),
    .NEXT_PTR (NEXT_PTR),
    .EXEC_SUP (EXEC_SUP),
    .PRIV_SUP (PRIV_SUP),
    .MAX_LOG2 (MAX_LOG2)
  ) u_cfg_regs (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (cfg_wr_en),
    .dw_off (cfg_dw_off),
    .be     (cfg_be),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .ctrl   (ctrl)
  );

  pasid_pfx_gate #(.MAX_LOG2(MAX_LOG2)) u_pfx_gate (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ctrl     (ctrl),
    .tx_valid (tx_valid),
    .tx_kind  (tx_kind),
    .tx_want  (tx_pasid_want),
    .tx_pasid (tx_pasid),
    .tx_exec  (tx_exec_req),
    .tx_priv  (tx_priv_req),
    .pout     (pout)
  );

  assign pfx_valid     = pout.vld;
  assign pfx_present   = pout.pfx;
  assign pfx_pasid     = pout.pasid;
  assign pfx_exec      = pout.exe;
  assign pfx_priv      = pout.prv;
  assign pfx_range_err = pout.err;

  // R12
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> !(pfx_valid || pfx_present || pfx_range_err));
endmodule

// File: tb/test_pasid_cap_gate.sv
module test_pasid_cap_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  dw_off = 3'd0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic        tv = 1'b0;
  logic [1:0]  tk = 2'b00;
  logic        tw = 1'b0;
  logic [19:0] tp = 20'h0;
  logic        te = 1'b0;
  logic        tpr = 1'b0;

  logic [31:0] rd_a, rd_b;
  logic        va, pa, ea, qa, ra, vb, pb, eb, qb, rb;
  logic [19:0] sa, sb;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [2:0]  ctrl_a = 3'b000;
  logic [2:0]  ctrl_b = 3'b000;
  logic [24:0] exp_a, exp_b;
  string       pfx_tag;
  bit          pend = 1'b0;

  always #4 clk = ~clk;

  pasid_cap_gate #(.NEXT_PTR(12'h140), .EXEC_SUP(1'b1), .PRIV_SUP(1'b0), .MAX_LOG2(12))
  i_pasid_cap_gate (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_dw_off(dw_off), .cfg_be(be),
    .cfg_wdata(wdata), .cfg_rdata(rd_a), .tx_valid(tv), .tx_kind(tk),
    .tx_pasid_want(tw), .tx_pasid(tp), .tx_exec_req(te), .tx_priv_req(tpr),
    .pfx_valid(va), .pfx_present(pa), .pfx_pasid(sa), .pfx_exec(ea),
    .pfx_priv(qa), .pfx_range_err(ra)
  );

  pasid_cap_gate #(.EXEC_SUP(1'b0), .PRIV_SUP(1'b1), .MAX_LOG2(20))
  i_pasid_cap_gate_alt (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_dw_off(dw_off), .cfg_be(be),
    .cfg_wdata(wdata), .cfg_rdata(rd_b), .tx_valid(tv), .tx_kind(tk),
    .tx_pasid_want(tw), .tx_pasid(tp), .tx_exec_req(te), .tx_priv_req(tpr),
    .pfx_valid(vb), .pfx_present(pb), .pfx_pasid(sb), .pfx_exec(eb),
    .pfx_priv(qb), .pfx_range_err(rb)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [24:0] exp_tx(input logic [2:0] c, input int maxw,
      input logic v, input logic [1:0] k, input logic w, input logic [19:0] p,
      input logic e, input logic pr);
    logic elig, oob, pfx;
    elig = v && w && c[0] && (k != 2'b10);
    oob  = (maxw < 20) && ((p >> maxw) != 20'h0);
    pfx  = elig && !oob;
    return {v, pfx, pfx & e & c[1], pfx & pr & c[2], elig & oob, pfx ? p : 20'h0};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] off, input logic [2:0] c,
      input logic [11:0] nxt, input logic [15:0] capw);
    if (off == 3'd0) return {nxt, 4'h1, 16'h001B};
    if (off == 3'd1) return {13'b0, c, capw};
    return 32'h0;
  endfunction

  task automatic chk_out(input string nm, input logic [24:0] act, input logic [24:0] exp);
    chk({"R10 valid ", nm}, 32'(act[24]), 32'(exp[24]));
    chk({pfx_tag, " present ", nm}, 32'(act[23]), 32'(exp[23]));
    chk({"R7 exec ", nm}, 32'(act[22]), 32'(exp[22]));
    chk({"R8 priv ", nm}, 32'(act[21]), 32'(exp[21]));
    chk({"R9 range_err ", nm}, 32'(act[20]), 32'(exp[20]));
    chk({"R10 pasid ", nm}, 32'(act[19:0]), 32'(exp[19:0]));
  endtask

  task automatic chk_rd(input logic [2:0] off);
    logic [31:0] ea32, eb32;
    ea32 = exp_rd(off, ctrl_a, 12'h140, 16'h0C02);
    eb32 = exp_rd(off, ctrl_b, 12'h000, 16'h1404);
    if (off == 3'd0) begin
      chk("R1 hdr A", rd_a, ea32);
      chk("R1 hdr B", rd_b, eb32);
    end else if (off == 3'd1) begin
      chk("R2 cap A", {16'h0, rd_a[15:0]}, {16'h0, ea32[15:0]});
      chk("R2 cap B", {16'h0, rd_b[15:0]}, {16'h0, eb32[15:0]});
      chk("R3 ctrl A", {16'h0, rd_a[31:16]}, {16'h0, ea32[31:16]});
      chk("R3 ctrl B", {16'h0, rd_b[31:16]}, {16'h0, eb32[31:16]});
    end else begin
      chk("R11 unmapped A", rd_a, ea32);
      chk("R11 unmapped B", rd_b, eb32);
    end
  endtask

  task automatic cyc(input logic we, input logic [2:0] off, input logic [3:0] b,
      input logic [31:0] wd, input logic v, input logic [1:0] k, input logic w,
      input logic [19:0] p, input logic e, input logic pr);
    @(negedge clk);
    if (pend) begin
      chk_out("A", {va, pa, ea, qa, ra, sa}, exp_a);
      chk_out("B", {vb, pb, eb, qb, rb, sb}, exp_b);
    end
    wr_en = we; dw_off = off; be = b; wdata = wd;
    tv = v; tk = k; tw = w; tp = p; te = e; tpr = pr;
    exp_a = exp_tx(ctrl_a, 12, v, k, w, p, e, pr);
    exp_b = exp_tx(ctrl_b, 20, v, k, w, p, e, pr);
    pfx_tag = (k == 2'b10) ? "R6" : (!ctrl_a[0] ? "R5" : "R9");
    pend = 1'b1;
    #1;
    chk_rd(off);
    if (we && off == 3'd1 && b[2]) begin
      ctrl_a = {1'b0, wd[17], wd[16]};
      ctrl_b = {wd[18], 1'b0, wd[16]};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    // R12: outputs quiet and control zero during reset
    repeat (3) @(negedge clk);
    tv = 1'b1; tw = 1'b1;
    #1;
    chk("R12 reset outputs A", {31'h0, va | pa | ra}, 32'h0);
    chk("R12 reset outputs B", {31'h0, vb | pb | rb}, 32'h0);
    dw_off = 3'd1; #1;
    chk("R12 reset ctrl A", {16'h0, rd_a[31:16]}, 32'h0);
    tv = 1'b0; tw = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R12 after release A", {31'h0, va | pa | ra}, 32'h0);

    // R1, R2, R11 reads and R5 requests before enabling
    cyc(0, 3'd0, 4'h0, 0, 1, 2'b00, 1, 20'h00ABC, 1, 1);
    cyc(0, 3'd1, 4'h0, 0, 1, 2'b01, 1, 20'h00123, 0, 1);
    cyc(1, 3'd0, 4'hF, 32'hFFFF_FFFF, 0, 2'b00, 0, 0, 0, 0);
    cyc(1, 3'd5, 4'hF, 32'hFFFF_FFFF, 1, 2'b11, 1, 20'h00010, 1, 0);
    cyc(0, 3'd5, 4'h0, 0, 0, 2'b00, 0, 0, 0, 0);
    // R3: write without byte enable 2 is ignored
    cyc(1, 3'd1, 4'hB, 32'hFFFF_FFFF, 0, 2'b00, 0, 0, 0, 0);
    cyc(0, 3'd1, 4'h0, 0, 0, 2'b00, 0, 0, 0, 0);
    // R4: all-ones write, unsupported enables stay 0
    cyc(1, 3'd1, 4'h4, 32'hFFFF_FFFF, 0, 2'b00, 0, 0, 0, 0);
    cyc(0, 3'd1, 4'h0, 0, 0, 2'b00, 0, 0, 0, 0);
    chk("R4 masked ctrl A", {16'h0, rd_a[31:16]}, 32'h3);
    chk("R4 masked ctrl B", {16'h0, rd_b[31:16]}, 32'h5);
    // R6 completion, R9 width boundary, R7/R8 gating
    cyc(0, 3'd1, 4'h0, 0, 1, 2'b10, 1, 20'h00005, 1, 1);
    cyc(0, 3'd1, 4'h0, 0, 1, 2'b00, 1, 20'h00FFF, 1, 1);
    cyc(0, 3'd1, 4'h0, 0, 1, 2'b01, 1, 20'h01000, 1, 1);
    cyc(0, 3'd1, 4'h0, 0, 1, 2'b11, 1, 20'hFFFFF, 1, 1);
    cyc(0, 3'd1, 4'h0, 0, 1, 2'b00, 0, 20'h00007, 1, 1);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic        we;
      logic [2:0]  off;
      logic [19:0] p;
      r   = $urandom;
      we  = (r[3:0] == 4'h0);
      off = r[4] ? 3'd1 : 3'(r[7:5]);
      p   = r[8] ? 20'($urandom) : 20'($urandom % 4096);
      cyc(we, off, 4'($urandom), $urandom, r[9] | r[10], 2'(r[12:11]),
          r[13] | r[14], p, r[15], r[16]);
    end
    cyc(0, 3'd0, 4'h0, 0, 0, 2'b00, 0, 0, 0, 0);

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule